// File: doc/BRIEF.md
# Quadrature Down-Converter with CIC Decimation

This block takes a stream of 14-bit signed real samples from a direct-sampling converter, nominally one sample per clock at 65 MHz. It mixes the stream to baseband against a cosine and sine pair from an internal numerically controlled oscillator, then reduces the rate of each path with a five-stage cascaded integrator-comb decimator. The output is one rounded, saturated 16-bit I/Q pair for every 1083 accepted input samples, which is close to 60 kS/s. Channel filtering and any output formatting take place downstream.

The oscillator is a 32-bit phase accumulator. The tuning word is a plain input that may change at any time. It is read only on cycles that carry a sample, and the phase already accumulated is kept across a retune, so the local oscillator stays phase-continuous. Input gaps (in_valid low) freeze the whole datapath.

Top module: `ddc_iq`

## Requirements
- R1: After reset, out_valid is 0, out_i and out_q are 0, and the phase accumulator holds 0.
- R2: Sample n is mixed at phase index p = the top 10 bits of the accumulator before that sample's update. With S(p) = round-half-away(32767·sin(2π(p+0.5)/1024)) and C(p) = S((p+256) mod 1024), the product fed to the I path is x·C(p) and the product fed to the Q path is −x·S(p).
- R3: On every cycle with in_valid high, the accumulator advances by the phase_inc value present in that cycle. A new increment therefore takes effect at the next sample boundary and leaves the accumulated phase unchanged.
- R4: Each path is filtered by five integrators and five combs at decimation 1083. Counting accepted samples from 0 after reset, an output is formed after sample n whenever (n+5) mod 1083 = 0. That output is the cascade response to all samples up to and including n.
- R5: The full-precision filter result v is scaled as floor((v + 2^61) / 2^62), which rounds half up.
- R6: A scaled value above 32767 is output as 32767. A scaled value below −32768 is output as −32768.
- R7: out_valid is high for exactly one cycle per output pair. out_i and out_q hold their values between pulses. Every formed output appears, in order.
- R8: Cycles with in_valid low have no effect on the outputs: they do not change the sample count, the filter state or the phase, whatever in_sample and phase_inc carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | High when in_sample carries a sample |
| in_sample | input | 14 | Signed input sample |
| phase_inc | input | 32 | Oscillator tuning word, read on valid cycles |
| out_valid | output | 1 | One-cycle strobe for a new I/Q pair |
| out_i | output | 16 | Signed in-phase baseband sample |
| out_q | output | 16 | Signed quadrature baseband sample |

## Verification
Two functions can fall in the same cycle: a retune and a sample, and the comb pipeline draining one decimated result while the integrators absorb the next input. The bench changes phase_inc on valid cycles, puts arbitrary increments and samples into gap cycles, and keeps samples streaming back to back across every decimation boundary. An independent wide-integer model follows the same sample sequence and is compared in order with every output pair. Any wrong phase, wrong alignment of the decimation point or comb corruption from overlapping activity shows up as a value mismatch or as a missing or extra output.

// File: rtl/ddc_iq.sv
module ddc_iq #(
  parameter int IN_W      = 14,
  parameter int LO_W      = 16,
  parameter int PH_W      = 32,
  parameter int LUT_AW    = 10,
  parameter int STAGES    = 5,
  parameter int DECIM     = 1083,
  parameter int OUT_W     = 16,
  parameter int OUT_SHIFT = 62
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_sample,
  input  logic [PH_W-1:0]         phase_inc,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_i,
  output logic signed [OUT_W-1:0] out_q
);
  localparam int QA     = LUT_AW - 2;
  localparam int QN     = 1 << QA;
  localparam int PROD_W = IN_W + LO_W;
  localparam int GROW   = STAGES * $clog2(DECIM);
  localparam int ACC_W  = PROD_W + GROW;
  localparam int CNT_W  = $clog2(DECIM);
  localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1) << (OUT_SHIFT - 1);
  localparam logic signed [ACC_W-1:0] OMAX = ACC_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] OMIN = -OMAX - 1;

  logic signed [LO_W-1:0] qtab [QN];
  initial begin
    for (int k = 0; k < QN; k++) begin
      real r;
      r = real'((1 << (LO_W - 1)) - 1) *
          $sin(2.0 * 3.14159265358979 * (real'(k) + 0.5) / real'(4 * QN));
      qtab[k] = LO_W'($rtoi(r >= 0.0 ? r + 0.5 : r - 0.5));
    end
  end

  function automatic logic signed [LO_W-1:0] lo_sin(input logic [LUT_AW-1:0] ph);
    logic [QA-1:0] idx;
    logic signed [LO_W-1:0] mag;
    idx = ph[LUT_AW-2] ? ~ph[QA-1:0] : ph[QA-1:0];
    mag = qtab[idx];
    return ph[LUT_AW-1] ? -mag : mag;
  endfunction

  function automatic logic signed [OUT_W-1:0] scale(input logic signed [ACC_W-1:0] v);
    logic signed [ACC_W-1:0] t;
    t = (v + RND) >>> OUT_SHIFT;
    if (t > OMAX) t = OMAX;
    else if (t < OMIN) t = OMIN;
    return t[OUT_W-1:0];
  endfunction

  logic [PH_W-1:0]          acc;
  logic [LUT_AW-1:0]        ph_r;
  logic signed [IN_W-1:0]   x1, x2;
  logic signed [LO_W-1:0]   lo_c, lo_s;
  logic signed [PROD_W-1:0] prod [2];
  logic                     v1, v2, v3;
  logic [CNT_W-1:0]         cnt;
  logic signed [ACC_W-1:0]  integ [2][STAGES];
  logic signed [ACC_W-1:0]  dly   [2][STAGES];
  logic signed [ACC_W-1:0]  cv    [2][STAGES];
  logic [STAGES:0]          dv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0; ph_r <= '0; x1 <= '0; x2 <= '0; lo_c <= '0; lo_s <= '0;
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      prod[0] <= '0; prod[1] <= '0;
    end else begin
      v1 <= in_valid; v2 <= v1; v3 <= v2;
      if (in_valid) begin
        ph_r <= acc[PH_W-1 -: LUT_AW];
        x1   <= in_sample;
        acc  <= acc + phase_inc;
      end
      if (v1) begin
        lo_c <= lo_sin(ph_r + LUT_AW'(QN));
        lo_s <= lo_sin(ph_r);
        x2   <= x1;
      end
      if (v2) begin
        prod[0] <= x2 * lo_c;
        prod[1] <= -(x2 * lo_s);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; dv <= '0;
      for (int c = 0; c < 2; c++)
        for (int k = 0; k < STAGES; k++) begin
          integ[c][k] <= '0; dly[c][k] <= '0; cv[c][k] <= '0;
        end
    end else begin
      dv <= {dv[STAGES-1:0], v3 && cnt == CNT_W'(DECIM - 1)};
      if (v3) begin
        cnt <= (cnt == CNT_W'(DECIM - 1)) ? '0 : cnt + 1'b1;
        for (int c = 0; c < 2; c++) begin
          integ[c][0] <= integ[c][0] + {{GROW{prod[c][PROD_W-1]}}, prod[c]};
          for (int k = 1; k < STAGES; k++)
            integ[c][k] <= integ[c][k] + integ[c][k-1];
        end
      end
      for (int c = 0; c < 2; c++)
        for (int k = 0; k < STAGES; k++)
          if (dv[k]) begin
            dly[c][k] <= (k == 0) ? integ[c][STAGES-1] : cv[c][k-1];
            cv[c][k]  <= ((k == 0) ? integ[c][STAGES-1] : cv[c][k-1]) - dly[c][k];
          end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_i <= '0; out_q <= '0;
    end else begin
      out_valid <= dv[STAGES];
      if (dv[STAGES]) begin
        out_i <= scale(cv[0][STAGES-1]);
        out_q <= scale(cv[1][STAGES-1]);
      end
    end
  end
endmodule

// File: rtl/ddc_iq_chk.sv
module ddc_iq_chk #(
  parameter int PH_W  = 32,
  parameter int DECIM = 1083,
  parameter int OUT_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [PH_W-1:0]         acc,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_i,
  input logic signed [OUT_W-1:0] out_q
);
  logic [31:0] gap;
  always_ff @(posedge clk) begin
    if (!rst_n) gap <= '0;
    else if (out_valid) gap <= '0;
    else if (gap < 32'(DECIM)) gap <= gap + 1;
  end

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R7
  pulse_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> gap >= 32'(DECIM - 1));

  // R8
  phase_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(acc));

  // R7
  hold_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_i) && $stable(out_q));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !$past(rst_n) |-> !out_valid && acc == '0);
endmodule

bind ddc_iq ddc_iq_chk #(.PH_W(PH_W), .DECIM(DECIM), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc(acc),
  .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
);

// File: tb/ddc_iq_tb.sv
module ddc_iq_tb;
  localparam int R = 1083;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [13:0] in_sample = '0;
  logic [31:0] phase_inc = '0;
  logic out_valid;
  logic signed [15:0] out_i, out_q;

  always #5 clk = ~clk;

  ddc_iq u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .phase_inc(phase_inc), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lo_s(int p);
    real r;
    r = 32767.0 * $sin(2.0 * 3.14159265358979 * (real'(p) + 0.5) / 1024.0);
    return $rtoi(r >= 0.0 ? r + 0.5 : r - 0.5);
  endfunction

  function automatic int rsat(logic signed [127:0] v);
    logic signed [127:0] one, t;
    one = 1;
    t = (v + (one <<< 61)) >>> 62;
    if (t > 32767) return 32767;
    if (t < -32768) return -32768;
    return int'(t);
  endfunction

  logic signed [127:0] si [2][5];
  logic signed [127:0] sd [2][5];
  logic [31:0] macc = '0;
  int nsamp = 0;
  int exp_i[$], exp_q[$];

  task automatic model(int x, logic [31:0] inc);
    int p;
    longint pr [2];
    p = int'(macc[31:22]);
    pr[0] = longint'(x) * longint'(lo_s((p + 256) % 1024));
    pr[1] = -(longint'(x) * longint'(lo_s(p)));
    for (int c = 0; c < 2; c++) begin
      si[c][0] += 128'(signed'(pr[c]));
      for (int k = 1; k < 5; k++) si[c][k] += si[c][k-1];
    end
    if ((nsamp + 5) % R == 0) begin
      for (int c = 0; c < 2; c++) begin
        logic signed [127:0] v, y;
        v = si[c][4];
        for (int k = 0; k < 5; k++) begin
          y = v - sd[c][k];
          sd[c][k] = v;
          v = y;
        end
        if (c == 0) exp_i.push_back(rsat(v)); else exp_q.push_back(rsat(v));
      end
    end
    nsamp++;
    macc += inc;
  endtask

  task automatic drive(int x, logic [31:0] inc, bit vld);
    @(negedge clk);
    in_valid  = vld;
    in_sample = 14'(x);
    phase_inc = inc;
    if (vld) model(x, inc);
  endtask

  bit prev_ov = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(!(prev_ov && out_valid), "R7 single-cycle strobe", longint'(out_valid), 0);
      if (out_valid) begin
        if (exp_i.size() == 0) chk(1'b0, "R7 unexpected output", 1, 0);
        else begin
          int ei, eq;
          ei = exp_i.pop_front();
          eq = exp_q.pop_front();
          chk(out_i == 16'(ei), "R4/R5/R6 I sample", longint'(out_i), longint'(ei));
          chk(out_q == 16'(eq), "R2/R3 Q sample", longint'(out_q), longint'(eq));
        end
      end
      prev_ov = out_valid;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "watchdog expired", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] inc;
    void'($urandom(32'd20240611));
    for (int c = 0; c < 2; c++)
      for (int k = 0; k < 5; k++) begin si[c][k] = '0; sd[c][k] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid", longint'(out_valid), 0);
    chk(out_i == 0, "R1 out_i", longint'(out_i), 0);
    chk(out_q == 0, "R1 out_q", longint'(out_q), 0);
    // R6 positive saturation, zero increment
    for (int i = 0; i < 10 * R; i++) drive(8191, 32'd0, 1'b1);
    // R6 negative saturation
    for (int i = 0; i < 6 * R; i++) drive(-8192, 32'd0, 1'b1);
    // R5 small values exercise rounding
    for (int i = 0; i < 5 * R; i++) drive(3, 32'd0, 1'b1);
    // R2 fixed tone near the oscillator
    for (int i = 0; i < 6 * R; i++) drive(((i % 8) < 4) ? 6000 : -6000, 32'h2000_0000, 1'b1);
    // R3 R8 random samples, retunes on valid cycles, junk in gaps
    inc = $urandom();
    for (int i = 0; i < 40 * R; i++) begin
      if (i % 1500 == 0) inc = $urandom();
      if ($urandom_range(3) == 0)
        drive(int'($urandom_range(16383)) - 8192, $urandom(), 1'b0);
      drive(int'($urandom_range(16383)) - 8192, inc, 1'b1);
    end
    drive(0, 32'd0, 1'b0);
    repeat (40) @(negedge clk);
    // R7 every formed output delivered
    chk(exp_i.size() == 0, "R7 outputs pending", longint'(exp_i.size()), 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule